// File: doc/BRIEF.md
# Buffered Three-Channel Sawtooth PWM Timer

This block is an up-counting timer that drives three PWM flip-flops sharing one period. One 16-bit counter runs from zero up to an active period value, then wraps to zero and gives a one-cycle cycle interrupt. The wrap also sets every channel flip-flop. Each channel has its own active duty value, and the channel's flip-flop is cleared when the counter reaches it.

Software may write the period value and the three duty values into shadow buffers at any time. The active compare registers take all four buffer values in one step, and only at a period wrap or when the timer is enabled. A waveform therefore never mixes values from two settings. Each channel also gives a one-cycle set strobe and a one-cycle clear strobe for every change of its flip-flop, so a separate dead-time stage can follow the edges.

Top module: `sawPwmTimer`

## Requirements
- R1: While enabled, the counter steps 0, 1, ..., P, where P is the active period value, then returns to 0. The period is P+1 cycles. `cycleIrq` is high for exactly the one cycle in which the counter is back at 0 after reaching P.
- R2: A write with `wrEn` high stores `wrData` in a shadow buffer. Address 0, 1 and 2 select the duty buffer of channel 0, 1 and 2. Address 3 selects the period buffer. A write has no effect on the period in progress. All four buffers become active together at the next period wrap.
- R3: A channel flip-flop goes high at the period wrap. With active duty value D < P, it stays high while the counter runs 0..D, and then goes low. That gives D+1 high cycles in each period of P+1 cycles.
- R4: A channel whose active duty value is greater than or equal to P is never cleared. It stays high for the whole period (100% duty).
- R5: While `enable` is low, the counter holds at 0, all flip-flops are low and `cycleIrq` is low. In the first cycle with `enable` high, the buffers are loaded into the active registers. From the next cycle, all flip-flops are high, and the counter starts from 0 one cycle later.
- R6: `setStrobe[i]` is high for exactly the one cycle in which `pwmOut[i]` has just gone from 0 to 1. `clrStrobe[i]` is high for exactly the one cycle in which `pwmOut[i]` has just gone from 1 to 0. This includes the clear caused by disabling the timer.
- R7: After reset, all outputs are low, and all buffers and active registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timer run control; its rising edge starts a fresh cycle |
| wrEn | input | 1 | Buffer write strobe |
| wrAddr | input | 2 | Buffer select: 0 to 2 select a duty buffer, 3 selects the period buffer |
| wrData | input | 16 | Value written to the selected buffer |
| cycleIrq | output | 1 | One-cycle pulse at each period wrap |
| pwmOut | output | 3 | Channel flip-flop outputs |
| setStrobe | output | 3 | One-cycle pulse when a flip-flop goes high |
| clrStrobe | output | 3 | One-cycle pulse when a flip-flop goes low |

## Verification
The assertions check properties on every cycle:
- The counter never passes the active period.
- The active registers change only on a load.
- A disabled timer keeps its outputs quiet.
- An enable edge sets every channel.
- The strobes always match the flip-flop transitions.

Other behaviour needs the bench's scenarios:
- The exact period length and high-time counts.
- The delay of a buffer write to the next period.
- The 100% duty case.

The bench shows these with directed measurements over whole periods, and with a cycle-by-cycle reference model driven by random writes and enable toggles.

// File: rtl/sawPwmPkg.sv
package sawPwmPkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;       // copy all shadow buffers to the active registers
    logic zeroCount;  // force the counter to zero
  } cntCtrl_t;
endpackage

// File: rtl/sawPwmDatapath.sv
module sawPwmDatapath
  import sawPwmPkg::*;
#(
  parameter int W  = 16,
  parameter int CH = 3,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntCtrl_t      ctl,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  output logic          periodMatch,
  output logic [CH-1:0] dutyMatch
);
  localparam int NREG = CH + 1;   // slot CH holds the period

  logic [W-1:0] shadowReg [NREG];
  logic [W-1:0] activeReg [NREG];
  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) shadowReg[i] <= '0;
    end else if (wrEn && (int'(wrAddr) < NREG)) begin
      shadowReg[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) activeReg[i] <= '0;
    end else if (ctl.load) begin
      for (int i = 0; i < NREG; i++) activeReg[i] <= shadowReg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (ctl.zeroCount) count <= '0;
    else                    count <= count + 1'b1;
  end

  assign periodMatch = (count == activeReg[CH]);

  for (genvar g = 0; g < CH; g++) begin : gDutyCmp
    assign dutyMatch[g] = (count == activeReg[g]);
  end

  // R1: the counter never runs past the active period
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= activeReg[CH]);

  // R2: the active period changes only on a load strobe
  a_r2_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(activeReg[CH]));
endmodule

// File: rtl/sawPwmControl.sv
module sawPwmControl
  import sawPwmPkg::*;
#(
  parameter int CH = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          periodMatch,
  input  logic [CH-1:0] dutyMatch,
  output cntCtrl_t      ctl,
  output logic          cycleIrq,
  output logic [CH-1:0] pwmOut,
  output logic [CH-1:0] setStrobe,
  output logic [CH-1:0] clrStrobe
);
  logic          enPrev;
  logic          startEvt;
  logic          periodHit;
  logic [CH-1:0] dutyHit;
  logic [CH-1:0] ffNext;

  assign startEvt  = enable & ~enPrev;
  assign periodHit = enable & ~startEvt & periodMatch;
  assign dutyHit   = {CH{enable & ~startEvt}} & dutyMatch;

  assign ctl.load      = startEvt | periodHit;
  assign ctl.zeroCount = ~enable | startEvt | periodHit;

  for (genvar g = 0; g < CH; g++) begin : gChan
    always_comb begin
      if (!enable)                    ffNext[g] = 1'b0;
      else if (startEvt || periodHit) ffNext[g] = 1'b1;  // set wins over a duty match
      else if (dutyHit[g])            ffNext[g] = 1'b0;
      else                            ffNext[g] = pwmOut[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev    <= 1'b0;
      cycleIrq  <= 1'b0;
      pwmOut    <= '0;
      setStrobe <= '0;
      clrStrobe <= '0;
    end else begin
      enPrev    <= enable;
      cycleIrq  <= periodHit;
      pwmOut    <= ffNext;
      setStrobe <= ffNext & ~pwmOut;
      clrStrobe <= pwmOut & ~ffNext;
    end
  end

  // R5: a disabled timer is quiet in the next cycle
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pwmOut == '0 && !cycleIrq));

  // R5: an enable edge sets every channel
  a_r5_start_sets: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !enPrev) |=> (pwmOut == {CH{1'b1}}));

  // R6: the strobes follow the flip-flop transitions
  a_r6_strobe_track: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (setStrobe == (pwmOut & ~$past(pwmOut)) &&
              clrStrobe == ($past(pwmOut) & ~pwmOut)));
endmodule

// File: rtl/sawPwmTimer.sv
module sawPwmTimer
  import sawPwmPkg::*;
#(
  parameter  int W  = 16,
  parameter  int CH = 3,
  localparam int AW = $clog2(CH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  output logic          cycleIrq,
  output logic [CH-1:0] pwmOut,
  output logic [CH-1:0] setStrobe,
  output logic [CH-1:0] clrStrobe
);
  cntCtrl_t      ctl;
  logic          periodMatch;
  logic [CH-1:0] dutyMatch;

  sawPwmDatapath #(.W(W), .CH(CH), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .periodMatch(periodMatch), .dutyMatch(dutyMatch)
  );

  sawPwmControl #(.CH(CH)) uCtl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .periodMatch(periodMatch), .dutyMatch(dutyMatch),
    .ctl(ctl), .cycleIrq(cycleIrq), .pwmOut(pwmOut),
    .setStrobe(setStrobe), .clrStrobe(clrStrobe)
  );
endmodule

// File: tb/tb_sawPwmTimer.sv
module tb_sawPwmTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic       cycleIrq;
  logic [2:0] pwmOut, setStrobe, clrStrobe;

  int nChecks = 0;
  int nFails  = 0;
  bit modelOn = 1'b0;

  sawPwmTimer dut (.*);

  always #5 clk = ~clk;

  // Reference model built from the requirements
  logic [15:0] mBuf [4];
  logic [15:0] mAct [4];
  logic [15:0] mCnt;
  logic        mEnPrev, mIrq;
  logic [2:0]  mFf, mSet, mClr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mBuf[i] = '0; mAct[i] = '0; end
      mCnt = '0; mEnPrev = 0; mIrq = 0; mFf = '0; mSet = '0; mClr = '0;
    end else begin
      logic st, ph;
      logic [2:0] nf;
      st = enable & ~mEnPrev;
      ph = enable & ~st & (mCnt == mAct[3]);
      for (int i = 0; i < 3; i++) begin
        if (!enable) nf[i] = 0;
        else if (st || ph) nf[i] = 1;
        else if (mCnt == mAct[i]) nf[i] = 0;
        else nf[i] = mFf[i];
      end
      mSet = nf & ~mFf; mClr = mFf & ~nf; mFf = nf; mIrq = ph;
      if (st || ph) for (int i = 0; i < 4; i++) mAct[i] = mBuf[i];
      mCnt = (!enable || st || ph) ? 16'd0 : mCnt + 16'd1;
      if (wrEn) mBuf[wrAddr] = wrData;
      mEnPrev = enable;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (modelOn) begin
    check("R1 irq", 32'(cycleIrq), 32'(mIrq));
    check(enable ? "R3 pwm" : "R5 pwm", 32'(pwmOut), 32'(mFf));
    check("R6 set", 32'(setStrobe), 32'(mSet));
    check("R6 clr", 32'(clrStrobe), 32'(mClr));
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 200 && !cycleIrq; i++) @(negedge clk);
  endtask

  // Start on an irq cycle; measure the period length and high counts per channel
  task automatic measure(output int n, output int hi [3]);
    n = 0;
    for (int c = 0; c < 3; c++) hi[c] = 0;
    do begin
      for (int c = 0; c < 3; c++) hi[c] += int'(pwmOut[c]);
      n++;
      @(negedge clk);
    end while (!cycleIrq && n < 200);
  endtask

  initial begin
    #1000000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int n, hi [3];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 irq", 32'(cycleIrq), 0);
    check("R7 pwm", 32'(pwmOut), 0);
    check("R7 strobes", 32'({setStrobe, clrStrobe}), 0);
    rstN = 1; modelOn = 1;
    @(negedge clk);
    // period 9, duties 3, 0, 12
    wr(2'd3, 16'd9); wr(2'd0, 16'd3); wr(2'd1, 16'd0); wr(2'd2, 16'd12);
    enable = 1;
    @(negedge clk);
    check("R5 start sets all", 32'(pwmOut), 32'h7);
    check("R6 start set strobes", 32'(setStrobe), 32'h7);
    waitIrq(); measure(n, hi);
    check("R1 period length", n, 10);
    check("R3 ch0 high time", hi[0], 4);
    check("R3 ch1 duty zero", hi[1], 1);
    check("R4 ch2 above period", hi[2], 10);
    // R2: mid-period writes leave the current period alone
    n = 2;
    wr(2'd3, 16'd5); wr(2'd0, 16'd2);
    while (!cycleIrq && n < 200) begin n++; @(negedge clk); end
    check("R2 current period kept", n, 10);
    measure(n, hi);
    check("R2 new period", n, 6);
    check("R2 new duty ch0", hi[0], 3);
    check("R4 ch2 stays full", hi[2], 6);
    // R4: duty equal to period
    wr(2'd1, 16'd5);
    waitIrq(); measure(n, hi);
    check("R4 duty equals period", hi[1], 6);
    // R5: disable
    enable = 0;
    @(negedge clk);
    check("R5 disabled pwm", 32'(pwmOut), 0);
    check("R6 disable clear strobes", 32'(clrStrobe), 32'h7);
    repeat (5) @(negedge clk);
    check("R5 disabled irq", 32'(cycleIrq), 0);
    enable = 1;
    @(negedge clk);
    check("R5 re-enable sets", 32'(pwmOut), 32'h7);
    // Random phase, checked cycle by cycle by the model
    for (int k = 0; k < 6000; k++) begin
      if ($urandom % 8 == 0) begin
        wrEn = 1; wrAddr = 2'($urandom % 4); wrData = 16'($urandom % 24);
      end else wrEn = 0;
      if ($urandom % 250 == 0) enable = ~enable;
      @(negedge clk);
    end
    wrEn = 0;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule